// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block handles the state changes a small 32-bit processor makes when it takes an exception and when it returns from one. The core presents a request with a 3-bit cause code and the program counter of the faulting or interrupted instruction. The block sorts the cause into one of two classes: ordinary (bus faults, divide by zero, interrupt, system call) or debug (breakpoint, watchpoint). It saves the program counter in the return register for that class and moves the global interrupt enable into that class's saved-enable bit. One clock later it presents the vector address, which is the selected base plus 32 bytes per cause code.

Two programmable base registers hold the ordinary and debug vector tables. A remap bit in the debug control register sends ordinary exceptions to the debug table as well. Two return strobes, one per class, restore the global enable from the saved bit and present the saved return address. The base registers, the remap bit and the global enable are loaded through a small register-write port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears both bases, the remap bit, the global enable, both saved-enable bits and both return registers, and drops `vec_valid`, `ret_valid` and `cause_err`.
- R2: When `cfg_wr_en` is high, `cfg_wr_sel` chooses the target: 0 is the ordinary base, 1 is the debug base, 2 is the remap bit (data bit 0), 3 is the global enable (data bit 0). Bits 7:0 of both bases always read zero.
- R3: A request with an ordinary cause (2 instruction bus error, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call) and the remap bit clear gives, one cycle later, `vec_valid`=1 and `vec_pc` = ordinary base + 32·cause. `exc_addr` takes the request PC.
- R4: A request with a debug cause (1 breakpoint, 3 watchpoint) gives, one cycle later, `vec_pc` = debug base + 32·cause. `dbg_addr` takes the request PC and `exc_addr` is unchanged.
- R5: When the remap bit is set, ordinary causes vector through the debug base. Debug causes use the debug base whatever the remap bit is.
- R6: An ordinary entry sets `saved_exc_en` if the global enable was 1 and leaves it unchanged if the enable was 0. It clears the global enable and leaves `saved_dbg_en` untouched.
- R7: A debug entry sets `saved_dbg_en` if the global enable was 1 and leaves it unchanged otherwise. It clears the global enable and leaves `saved_exc_en` untouched.
- R8: A request with cause 0 (the reset code) does not vector. One cycle later it pulses `cause_err` with `vec_valid` low, and it changes no return register or enable bit.
- R9: An ordinary-return strobe gives, one cycle later, `ret_valid`=1 with `ret_pc` = `exc_addr`, and loads the global enable from `saved_exc_en`.
- R10: A debug-return strobe gives, one cycle later, `ret_valid`=1 with `ret_pc` = `dbg_addr`, and loads the global enable from `saved_dbg_en`.
- R11: For the global enable and the result outputs, the order of precedence is request, then ordinary return, then debug return, then a register write. A base or remap write in the same cycle as a request still lands, but that request vectors with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Exception request strobe |
| req_cause | input | 3 | Cause code of the request |
| req_pc | input | 32 | Program counter to save |
| eret_strobe | input | 1 | Return from an ordinary exception |
| bret_strobe | input | 1 | Return from a debug exception |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register write target |
| cfg_wr_data | input | 32 | Register write data |
| vec_valid | output | 1 | Vector address valid (one cycle) |
| vec_pc | output | 32 | Vector address |
| ret_valid | output | 1 | Return target valid (one cycle) |
| ret_pc | output | 32 | Return target |
| cause_err | output | 1 | Undefined cause seen (one cycle) |
| gie | output | 1 | Global interrupt enable |
| saved_exc_en | output | 1 | Saved enable, ordinary class |
| saved_dbg_en | output | 1 | Saved enable, debug class |
| exc_addr | output | 32 | Ordinary return address register |
| dbg_addr | output | 32 | Debug return address register |
| exc_base | output | 32 | Ordinary vector base |
| dbg_base | output | 32 | Debug vector base |
| remap_dbg | output | 1 | Ordinary-to-debug remap bit |

## Verification
Requests are issued with causes from both classes and with the low write bits of the bases non-zero. A vector that lands in the wrong table, in the wrong slot, or off the 256-byte alignment therefore gives a different address. Each entry is tried once with the global enable set and once with it clear. This separates a saved bit that only gets set from one that is simply overwritten, and also shows whether the other class's saved bit is disturbed. The remap bit is toggled under both classes. Requests collide with returns and base writes in the same cycle, which exposes the precedence order and the use of old register values. Cause 0 is sent with the enable set, so any state change it made would show.

// File: rtl/exc_entry_pkg.sv
// Package: shared codes for the exception entry controller.
// Assumes a 3-bit cause field and a 2-bit register-write select.
package exc_entry_pkg;

    localparam int CAUSE_W = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_RESET = 3'd0,
        CAUSE_BREAK = 3'd1,
        CAUSE_IBUS  = 3'd2,
        CAUSE_WATCH = 3'd3,
        CAUSE_DBUS  = 3'd4,
        CAUSE_DIVZ  = 3'd5,
        CAUSE_IRQ   = 3'd6,
        CAUSE_SCALL = 3'd7
    } cause_e;

    typedef enum logic [1:0] {
        SEL_EBASE = 2'd0,
        SEL_DBASE = 2'd1,
        SEL_DCTRL = 2'd2,
        SEL_GIE   = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_ORD  = 2'd1,
        CLS_DBG  = 2'd2
    } cls_e;

endpackage

// File: rtl/exc_base_regs.sv
// Module: vector base registers and the remap bit.
// Keeps only the bits above ALIGN_BITS of each base so that a vector
// table is always aligned. Assumes one write per cycle.
module exc_base_regs #(
    parameter int XLEN       = 32,
    parameter int ALIGN_BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] ebase,
    output logic [XLEN-1:0] dbase,
    output logic            remap
);
    import exc_entry_pkg::*;

    localparam logic [XLEN-1:0] LOW_MASK = XLEN'((64'd1 << ALIGN_BITS) - 64'd1);

    logic [XLEN-1:0] aligned_data;

    // Clear the bits below the table alignment.
    always_comb begin
        aligned_data = wr_data & ~LOW_MASK;
    end

    // Load the register chosen by the select field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ebase <= '0;
            dbase <= '0;
            remap <= 1'b0;
        end else if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_EBASE: ebase <= aligned_data;
                SEL_DBASE: dbase <= aligned_data;
                SEL_DCTRL: remap <= wr_data[0];
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/exc_vector_calc.sv
// Module: sorts a cause into its class and forms the vector address.
// Purely combinational. Assumes the bases are already aligned, so the
// sum never carries into the base bits.
module exc_vector_calc #(
    parameter int XLEN       = 32,
    parameter int SLOT_SHIFT = 5
) (
    input  logic [exc_entry_pkg::CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]                   ebase,
    input  logic [XLEN-1:0]                   dbase,
    input  logic                              remap,
    output exc_entry_pkg::cls_e               cls,
    output logic [XLEN-1:0]                   target
);
    import exc_entry_pkg::*;

    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] base_sel;

    // Sort the cause code into ordinary, debug or undefined.
    always_comb begin
        case (cause_e'(cause))
            CAUSE_BREAK, CAUSE_WATCH: cls = CLS_DBG;
            CAUSE_IBUS, CAUSE_DBUS, CAUSE_DIVZ,
            CAUSE_IRQ, CAUSE_SCALL:   cls = CLS_ORD;
            default:                  cls = CLS_NONE;
        endcase
    end

    // Pick the base and add the slot offset of the cause.
    always_comb begin
        offset   = XLEN'(cause) << SLOT_SHIFT;
        base_sel = (cls == CLS_ORD && !remap) ? ebase : dbase;
        target   = base_sel + offset;
    end

endmodule

// File: rtl/exc_enable_state.sv
// Module: global enable, saved-enable bits and the two return registers.
// Assumes the caller has already resolved priority, so at most one of
// take_ord, take_dbg, do_eret and do_bret is high.
module exc_enable_state #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take_ord,
    input  logic            take_dbg,
    input  logic            do_eret,
    input  logic            do_bret,
    input  logic            gie_wr,
    input  logic            gie_wr_val,
    input  logic [XLEN-1:0] pc,
    output logic            gie,
    output logic            sav_e,
    output logic            sav_b,
    output logic [XLEN-1:0] ea,
    output logic [XLEN-1:0] ba
);

    // Update the enable bits by priority: entry, return, then a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie   <= 1'b0;
            sav_e <= 1'b0;
            sav_b <= 1'b0;
        end else if (take_ord) begin
            if (gie) sav_e <= 1'b1;
            gie <= 1'b0;
        end else if (take_dbg) begin
            if (gie) sav_b <= 1'b1;
            gie <= 1'b0;
        end else if (do_eret) begin
            gie <= sav_e;
        end else if (do_bret) begin
            gie <= sav_b;
        end else if (gie_wr) begin
            gie <= gie_wr_val;
        end
    end

    // Save the program counter in the return register of the class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea <= '0;
            ba <= '0;
        end else if (take_ord) begin
            ea <= pc;
        end else if (take_dbg) begin
            ba <= pc;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Module: exception entry and return controller (top).
// Resolves priority among the request, the two return strobes and the
// register port. Registers the vector, return and error results one
// cycle after their cause. Assumes a request has a valid PC.
module exc_entry_ctrl #(
    parameter int XLEN       = 32,
    parameter int SLOT_SHIFT = 5,
    parameter int ALIGN_BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_cause,
    input  logic [XLEN-1:0] req_pc,
    input  logic            eret_strobe,
    input  logic            bret_strobe,
    input  logic            cfg_wr_en,
    input  logic [1:0]      cfg_wr_sel,
    input  logic [XLEN-1:0] cfg_wr_data,
    output logic            vec_valid,
    output logic [XLEN-1:0] vec_pc,
    output logic            ret_valid,
    output logic [XLEN-1:0] ret_pc,
    output logic            cause_err,
    output logic            gie,
    output logic            saved_exc_en,
    output logic            saved_dbg_en,
    output logic [XLEN-1:0] exc_addr,
    output logic [XLEN-1:0] dbg_addr,
    output logic [XLEN-1:0] exc_base,
    output logic [XLEN-1:0] dbg_base,
    output logic            remap_dbg
);
    import exc_entry_pkg::*;

    cls_e            cls;
    logic [XLEN-1:0] target;
    logic            take_ord, take_dbg, bad_cause;
    logic            do_eret, do_bret, gie_wr;

    exc_base_regs #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_bases (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .ebase   (exc_base),
        .dbase   (dbg_base),
        .remap   (remap_dbg)
    );

    exc_vector_calc #(.XLEN(XLEN), .SLOT_SHIFT(SLOT_SHIFT)) u_vec (
        .cause  (req_cause),
        .ebase  (exc_base),
        .dbase  (dbg_base),
        .remap  (remap_dbg),
        .cls    (cls),
        .target (target)
    );

    // Resolve precedence: request, ordinary return, debug return, write.
    always_comb begin
        take_ord  = req_valid && (cls == CLS_ORD);
        take_dbg  = req_valid && (cls == CLS_DBG);
        bad_cause = req_valid && (cls == CLS_NONE);
        do_eret   = eret_strobe && !req_valid;
        do_bret   = bret_strobe && !req_valid && !eret_strobe;
        gie_wr    = cfg_wr_en && (wsel_e'(cfg_wr_sel) == SEL_GIE);
    end

    exc_enable_state #(.XLEN(XLEN)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_ord   (take_ord),
        .take_dbg   (take_dbg),
        .do_eret    (do_eret),
        .do_bret    (do_bret),
        .gie_wr     (gie_wr),
        .gie_wr_val (cfg_wr_data[0]),
        .pc         (req_pc),
        .gie        (gie),
        .sav_e      (saved_exc_en),
        .sav_b      (saved_dbg_en),
        .ea         (exc_addr),
        .ba         (dbg_addr)
    );

    // Register the vector, return target and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_pc    <= '0;
            ret_valid <= 1'b0;
            ret_pc    <= '0;
            cause_err <= 1'b0;
        end else begin
            vec_valid <= take_ord || take_dbg;
            cause_err <= bad_cause;
            ret_valid <= do_eret || do_bret;
            if (take_ord || take_dbg) vec_pc <= target;
            if (do_eret)      ret_pc <= exc_addr;
            else if (do_bret) ret_pc <= dbg_addr;
        end
    end

endmodule

// File: rtl/exc_entry_checks.sv
// Module: timing properties of the exception entry controller, bound
// to the top. Assumes the default slot and alignment sizes.
module exc_entry_checks #(
    parameter int XLEN       = 32,
    parameter int SLOT_SHIFT = 5,
    parameter int ALIGN_BITS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_cause,
    input logic            eret_strobe,
    input logic            vec_valid,
    input logic [XLEN-1:0] vec_pc,
    input logic            ret_valid,
    input logic [XLEN-1:0] ret_pc,
    input logic            cause_err,
    input logic            gie,
    input logic            saved_exc_en,
    input logic [XLEN-1:0] exc_addr,
    input logic [XLEN-1:0] exc_base,
    input logic [XLEN-1:0] dbg_base
);

    assert_base_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_base[ALIGN_BITS-1:0] == '0 && dbg_base[ALIGN_BITS-1:0] == '0);

    assert_vec_slot_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> vec_pc[SLOT_SHIFT-1:0] == '0);

    assert_entry_clears_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cause != 3'd0) |=> (vec_valid && !gie));

    assert_dbg_keeps_ea_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_cause == 3'd1 || req_cause == 3'd3)) |=> $stable(exc_addr));

    assert_bad_cause_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cause == 3'd0) |=> (cause_err && !vec_valid && $stable(exc_addr)));

    assert_eret_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_strobe && !req_valid) |=> (ret_valid && gie == $past(saved_exc_en)
                                         && ret_pc == $past(exc_addr)));

    assert_one_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({vec_valid, ret_valid, cause_err}) <= 1);

endmodule

bind exc_entry_ctrl exc_entry_checks #(
    .XLEN(XLEN), .SLOT_SHIFT(SLOT_SHIFT), .ALIGN_BITS(ALIGN_BITS)
) u_exc_entry_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_cause    (req_cause),
    .eret_strobe  (eret_strobe),
    .vec_valid    (vec_valid),
    .vec_pc       (vec_pc),
    .ret_valid    (ret_valid),
    .ret_pc       (ret_pc),
    .cause_err    (cause_err),
    .gie          (gie),
    .saved_exc_en (saved_exc_en),
    .exc_addr     (exc_addr),
    .exc_base     (exc_base),
    .dbg_base     (dbg_base)
);

// File: tb/tb_exc_entry_ctrl.sv
// Directed bench for the exception entry controller.
module tb_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, eret_strobe, bret_strobe, cfg_wr_en;
    logic [2:0]  req_cause;
    logic [1:0]  cfg_wr_sel;
    logic [31:0] req_pc, cfg_wr_data;
    logic        vec_valid, ret_valid, cause_err, gie, saved_exc_en, saved_dbg_en, remap_dbg;
    logic [31:0] vec_pc, ret_pc, exc_addr, dbg_addr, exc_base, dbg_base;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [31:0] EB = 32'h1234_5600;
    localparam logic [31:0] DB = 32'hABCD_0000;

    always #4 clk = ~clk;

    exc_entry_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
        .req_pc(req_pc), .eret_strobe(eret_strobe), .bret_strobe(bret_strobe),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .vec_valid(vec_valid), .vec_pc(vec_pc), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .cause_err(cause_err), .gie(gie), .saved_exc_en(saved_exc_en),
        .saved_dbg_en(saved_dbg_en), .exc_addr(exc_addr), .dbg_addr(dbg_addr),
        .exc_base(exc_base), .dbg_base(dbg_base), .remap_dbg(remap_dbg)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; eret_strobe = 0; bret_strobe = 0; cfg_wr_en = 0;
        req_cause = 0; req_pc = 0; cfg_wr_sel = 0; cfg_wr_data = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_data = d;
        tick();
    endtask

    task automatic raise(logic [2:0] c, logic [31:0] pc);
        req_valid = 1; req_cause = c; req_pc = pc;
        tick();
    endtask

    // R1: reset state
    task automatic t_reset();
        idle(); rst_n = 0;
        repeat (2) @(posedge clk); #1;
        rst_n = 1;
        check("R1 gie", {31'd0, gie}, 0);
        check("R1 exc_base", exc_base, 0);
        check("R1 dbg_base", dbg_base, 0);
        check("R1 exc_addr", exc_addr, 0);
        check("R1 outputs", {29'd0, vec_valid, ret_valid, cause_err}, 0);
    endtask

    // R2: register port with low base bits dropped
    task automatic t_write();
        wr(2'd0, EB | 32'hFF);
        check("R2 exc_base low bits", exc_base, EB);
        wr(2'd1, DB | 32'h80);
        check("R2 dbg_base low bits", dbg_base, DB);
        wr(2'd3, 32'h1);
        check("R2 gie write", {31'd0, gie}, 1);
        check("R2 remap untouched", {31'd0, remap_dbg}, 0);
    endtask

    // R3 R6: ordinary entries with the enable set and then clear
    task automatic t_ordinary();
        raise(3'd6, 32'h100);
        check("R3 vec_valid", {31'd0, vec_valid}, 1);
        check("R3 vec_pc irq", vec_pc, EB + 32'hC0);
        check("R3 exc_addr", exc_addr, 32'h100);
        check("R6 saved_exc_en set", {31'd0, saved_exc_en}, 1);
        check("R6 gie cleared", {31'd0, gie}, 0);
        check("R6 saved_dbg_en untouched", {31'd0, saved_dbg_en}, 0);
        raise(3'd2, 32'h204);
        check("R3 vec_pc ibus", vec_pc, EB + 32'h40);
        check("R6 saved_exc_en kept when gie 0", {31'd0, saved_exc_en}, 1);
    endtask

    // R9: ordinary return
    task automatic t_eret();
        eret_strobe = 1;
        tick();
        check("R9 ret_valid", {31'd0, ret_valid}, 1);
        check("R9 ret_pc", ret_pc, 32'h204);
        check("R9 gie restored", {31'd0, gie}, 1);
    endtask

    // R4 R7 R10: debug entry and return
    task automatic t_debug();
        raise(3'd1, 32'h300);
        check("R4 vec_pc break", vec_pc, DB + 32'h20);
        check("R4 dbg_addr", dbg_addr, 32'h300);
        check("R4 exc_addr unchanged", exc_addr, 32'h204);
        check("R7 saved_dbg_en set", {31'd0, saved_dbg_en}, 1);
        check("R7 gie cleared", {31'd0, gie}, 0);
        wr(2'd0, EB);
        bret_strobe = 1;
        tick();
        check("R10 ret_valid", {31'd0, ret_valid}, 1);
        check("R10 ret_pc", ret_pc, 32'h300);
        check("R10 gie restored", {31'd0, gie}, 1);
        wr(2'd3, 32'h0);
        raise(3'd3, 32'h310);
        check("R7 saved_dbg_en kept when gie 0", {31'd0, saved_dbg_en}, 1);
        check("R4 vec_pc watch", vec_pc, DB + 32'h60);
    endtask

    // R5: remap sends ordinary causes to the debug table
    task automatic t_remap();
        wr(2'd2, 32'h1);
        check("R5 remap set", {31'd0, remap_dbg}, 1);
        raise(3'd7, 32'h400);
        check("R5 vec_pc scall remapped", vec_pc, DB + 32'hE0);
        check("R5 exc_addr", exc_addr, 32'h400);
        raise(3'd3, 32'h500);
        check("R5 vec_pc watch remapped", vec_pc, DB + 32'h60);
        wr(2'd2, 32'h0);
        raise(3'd4, 32'h600);
        check("R5 vec_pc dbus after clear", vec_pc, EB + 32'h80);
    endtask

    // R8: undefined cause 0
    task automatic t_bad();
        wr(2'd3, 32'h1);
        raise(3'd0, 32'h700);
        check("R8 cause_err", {31'd0, cause_err}, 1);
        check("R8 no vec_valid", {31'd0, vec_valid}, 0);
        check("R8 exc_addr unchanged", exc_addr, 32'h600);
        check("R8 dbg_addr unchanged", dbg_addr, 32'h500);
        check("R8 gie unchanged", {31'd0, gie}, 1);
        tick();
        check("R8 err one cycle", {31'd0, cause_err}, 0);
    endtask

    // R11: collisions in one cycle
    task automatic t_priority();
        req_valid = 1; req_cause = 3'd5; req_pc = 32'h800;
        eret_strobe = 1;
        cfg_wr_en = 1; cfg_wr_sel = 2'd0; cfg_wr_data = 32'h5555_0000;
        tick();
        check("R11 request uses old base", vec_pc, EB + 32'hA0);
        check("R11 no return with request", {31'd0, ret_valid}, 0);
        check("R11 base write lands", exc_base, 32'h5555_0000);
        check("R11 gie cleared by request", {31'd0, gie}, 0);
        eret_strobe = 1; bret_strobe = 1;
        tick();
        check("R11 eret beats bret", ret_pc, 32'h800);
        eret_strobe = 1; cfg_wr_en = 1; cfg_wr_sel = 2'd3; cfg_wr_data = 32'h0;
        tick();
        check("R11 eret beats gie write", {31'd0, gie}, 1);
    endtask

    initial begin
        idle();
        rst_n = 0;
        t_reset();
        t_write();
        t_ordinary();
        t_eret();
        t_debug();
        t_remap();
        t_bad();
        t_priority();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule